// File: doc/BRIEF.md
# Host Bus Slave Handshake Sequencer

This block runs the slave side of a 16-bit processor bus access. The bus strobes arrive without any relation to the receive clock. The block resynchronizes them, then produces three signals: an active-low enable for external bidirectional data buffers, an active-low direction signal for those buffers, and an active-low ready with its own output enable, because ready is meant to float between accesses. Every delay is counted in rising edges of the receive clock. The count depends on the direction of the access and on which internal target the address selects: the register file, the instruction buffer, the associative-memory port or the FIFO.

A mode input picks one of two strobe styles. In the first, separate write and read strobes mark the access. In the second, an upper and a lower data strobe mark it, a read/write level gives the direction, and each strobe enables its own byte lane. While an access is active, the block gives the neighbouring storage three things. It gives a one-hot target select and a byte-lane mask. For writes it gives a one-cycle capture pulse, and for reads a drive-enable that opens the read data path.

Top module: `hbus_handshake`

## Requirements
- R1: While reset is held and directly after it, `buf_en_n`, `buf_dir_n` and `rdy_n` are 1, and `rdy_oe`, `wr_cap`, `rd_drive`, `tgt_sel` and `byte_en` are 0.
- R2: A strobe level sampled low at edge t passes through a two-flop synchronizer, so the sequencer detects it at edge t+2. For a write, `buf_en_n` and `buf_dir_n` go low at edge t+3, and `rdy_oe` goes to 1 at the same edge.
- R3: For a read, `buf_en_n` goes low at edge t+4 while `buf_dir_n` stays 1, and `rdy_oe` goes to 1 at the same edge.
- R4: For a write, `rdy_n` falls N edges after the edge on which `buf_en_n` fell. N is 2 for target code 0 (register file), 2 for code 1 (instruction buffer), 8 for code 2 (associative memory) and 5 for code 3 (FIFO).
- R5: For a read, `rdy_n` falls N edges after `buf_en_n` falls. N is 1 for code 0, 4 for code 1, 7 for code 2 and 4 for code 3.
- R6: On a write, `wr_cap` is high for exactly the one cycle that starts at the edge where `rdy_n` falls. On a read, `rd_drive` rises one edge before `rdy_n` falls, or together with `buf_en_n` when N is 1, and stays high until release.
- R7: After ready has been given, a strobe release sampled at edge t raises `rdy_n` at edge t+2. At edge t+3, `buf_en_n` and `buf_dir_n` return to 1 and `rdy_oe` returns to 0.
- R8: If the synchronized strobe is found released on any edge before `rdy_n` would fall, including that very edge, every output returns to idle on that edge and `rdy_n` never falls for the access.
- R9: With `mode_ds`=0, `wr_n` low marks a write and `rd_n` low marks a read, write winning if both are low, and `byte_en` is 2'b11. With `mode_ds`=1, either data strobe low marks an access and `rnw`=1 makes it a read. `byte_en`[1] is taken from `uds_n` low and `byte_en`[0] from `lds_n` low, both captured at detection.
- R10: From the detection edge until the edge that ends the release, `tgt_sel` is one-hot with bit k set for the latched target code k. At all other times it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; every delay counts its rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ds | input | 1 | 0: separate read/write strobes; 1: upper/lower data strobes |
| wr_n | input | 1 | Write strobe, active low (mode 0) |
| rd_n | input | 1 | Read strobe, active low (mode 0) |
| uds_n | input | 1 | Upper data strobe, active low (mode 1) |
| lds_n | input | 1 | Lower data strobe, active low (mode 1) |
| rnw | input | 1 | 1 = read, 0 = write (mode 1) |
| tgt | input | 2 | Target code: 0 register, 1 instruction buffer, 2 memory, 3 FIFO |
| buf_en_n | output | 1 | External data buffer enable, active low |
| buf_dir_n | output | 1 | Buffer direction, low for a write into the block |
| rdy_n | output | 1 | Ready, active low |
| rdy_oe | output | 1 | Drive enable for the ready pin; 0 means high impedance |
| wr_cap | output | 1 | One-cycle write data capture pulse |
| rd_drive | output | 1 | Read data drive enable |
| tgt_sel | output | 4 | One-hot select of the latched target |
| byte_en | output | 2 | Byte lanes of the access, upper in bit 1 |

## Verification
Two events can fall on the same clock edge: the completion of the ready count and the release of the strobe. When they do, release must win and ready must stay high. The bench provokes this by sweeping the strobe hold time one cycle at a time over every target in both directions, so that the synchronized release lands before, on and after each ready edge. A behavioural model counts edges from detection and checks each cycle whether the access completed or returned to idle without ready.

// File: rtl/hbh_pkg.sv
package hbh_pkg;
  typedef enum logic [1:0] {
    TGT_REG  = 2'd0,
    TGT_IBUF = 2'd1,
    TGT_MEM  = 2'd2,
    TGT_FIFO = 2'd3
  } tgt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EN,
    ST_RDY,
    ST_HOLD,
    ST_REL
  } hs_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/hbh_sync.sv
module hbh_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic st1, st2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1 <= 1'b1;
        st2 <= 1'b1;
      end else begin
        st1 <= d[i];
        st2 <= st1;
      end
    end
    assign q[i] = st2;
  end
endmodule

// File: rtl/hbh_delay.sv
module hbh_delay #(
  parameter int CW       = 4,
  parameter int WR_EN    = 2,
  parameter int RD_EN    = 3,
  parameter int WR_REG   = 2,
  parameter int WR_IBUF  = 2,
  parameter int WR_MEM   = 8,
  parameter int WR_FIFO  = 5,
  parameter int RD_REG   = 1,
  parameter int RD_IBUF  = 4,
  parameter int RD_MEM   = 7,
  parameter int RD_FIFO  = 4
) (
  input  logic          is_wr,
  input  logic [1:0]    tgt,
  output logic [CW-1:0] en_load,
  output logic [CW-1:0] rdy_load
);
  import hbh_pkg::*;

  // counter loads: edges after detection minus two, edges to ready minus one
  localparam logic [CW-1:0] WE = CW'(WR_EN - 2);
  localparam logic [CW-1:0] RE = CW'(RD_EN - 2);

  always_comb begin
    en_load = is_wr ? WE : RE;
    unique case (tgt_e'(tgt))
      TGT_REG:  rdy_load = is_wr ? CW'(WR_REG - 1)  : CW'(RD_REG - 1);
      TGT_IBUF: rdy_load = is_wr ? CW'(WR_IBUF - 1) : CW'(RD_IBUF - 1);
      TGT_MEM:  rdy_load = is_wr ? CW'(WR_MEM - 1)  : CW'(RD_MEM - 1);
      default:  rdy_load = is_wr ? CW'(WR_FIFO - 1) : CW'(RD_FIFO - 1);
    endcase
  end
endmodule

// File: rtl/hbus_handshake.sv
module hbus_handshake
  import hbh_pkg::*;
#(
  parameter int WR_EN    = 2,
  parameter int RD_EN    = 3,
  parameter int WR_REG   = 2,
  parameter int WR_IBUF  = 2,
  parameter int WR_MEM   = 8,
  parameter int WR_FIFO  = 5,
  parameter int RD_REG   = 1,
  parameter int RD_IBUF  = 4,
  parameter int RD_MEM   = 7,
  parameter int RD_FIFO  = 4,
  parameter int NTGT     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_ds,
  input  logic            wr_n,
  input  logic            rd_n,
  input  logic            uds_n,
  input  logic            lds_n,
  input  logic            rnw,
  input  logic [1:0]      tgt,
  output logic            buf_en_n,
  output logic            buf_dir_n,
  output logic            rdy_n,
  output logic            rdy_oe,
  output logic            wr_cap,
  output logic            rd_drive,
  output logic [NTGT-1:0] tgt_sel,
  output logic [1:0]      byte_en
);
  localparam int MAXD = max2(max2(max2(WR_MEM, WR_FIFO), max2(RD_MEM, RD_FIFO)),
                             max2(max2(WR_REG, WR_IBUF), max2(max2(RD_REG, RD_IBUF),
                                                              max2(WR_EN, RD_EN))));
  localparam int CW = $clog2(MAXD + 1);

  logic [3:0] s_in;
  hbh_sync #(.W(4)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({wr_n, rd_n, uds_n, lds_n}),
    .q(s_in)
  );

  logic s_wr, s_rd, s_uds, s_lds;
  assign {s_wr, s_rd, s_uds, s_lds} = s_in;

  logic ds_any, act_wr, act_rd;
  assign ds_any = ~s_uds | ~s_lds;
  assign act_wr = mode_ds ? (ds_any & ~rnw) : ~s_wr;
  assign act_rd = mode_ds ? (ds_any & rnw)  : ~s_rd;

  hs_state_e     st;
  logic          is_wr;
  logic [1:0]    lat_tgt;
  logic [1:0]    lat_be;
  logic [CW-1:0] cnt;
  logic          cur_act;
  assign cur_act = is_wr ? act_wr : act_rd;

  logic          lut_wr;
  logic [1:0]    lut_tgt;
  logic [CW-1:0] en_load, rdy_load;
  assign lut_wr  = (st == ST_IDLE) ? act_wr : is_wr;
  assign lut_tgt = (st == ST_IDLE) ? tgt : lat_tgt;

  hbh_delay #(
    .CW(CW), .WR_EN(WR_EN), .RD_EN(RD_EN),
    .WR_REG(WR_REG), .WR_IBUF(WR_IBUF), .WR_MEM(WR_MEM), .WR_FIFO(WR_FIFO),
    .RD_REG(RD_REG), .RD_IBUF(RD_IBUF), .RD_MEM(RD_MEM), .RD_FIFO(RD_FIFO)
  ) u_delay (
    .is_wr(lut_wr), .tgt(lut_tgt), .en_load(en_load), .rdy_load(rdy_load)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      is_wr     <= 1'b0;
      lat_tgt   <= '0;
      lat_be    <= '0;
      cnt       <= '0;
      buf_en_n  <= 1'b1;
      buf_dir_n <= 1'b1;
      rdy_n     <= 1'b1;
      rdy_oe    <= 1'b0;
      wr_cap    <= 1'b0;
      rd_drive  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (act_wr || act_rd) begin
            is_wr   <= act_wr;
            lat_tgt <= tgt;
            lat_be  <= mode_ds ? {~s_uds, ~s_lds} : 2'b11;
            cnt     <= en_load;
            st      <= ST_EN;
          end
        end
        ST_EN: begin
          if (!cur_act) begin
            st <= ST_IDLE;
          end else if (cnt == '0) begin
            buf_en_n  <= 1'b0;
            buf_dir_n <= ~is_wr;
            rdy_oe    <= 1'b1;
            cnt       <= rdy_load;
            if (!is_wr && rdy_load == '0) rd_drive <= 1'b1;
            st        <= ST_RDY;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RDY: begin
          if (!cur_act) begin
            buf_en_n  <= 1'b1;
            buf_dir_n <= 1'b1;
            rdy_oe    <= 1'b0;
            rd_drive  <= 1'b0;
            st        <= ST_IDLE;
          end else if (cnt == '0) begin
            rdy_n  <= 1'b0;
            wr_cap <= is_wr;
            st     <= ST_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
            if (!is_wr && cnt == CW'(1)) rd_drive <= 1'b1;
          end
        end
        ST_HOLD: begin
          wr_cap <= 1'b0;
          if (!cur_act) begin
            rdy_n <= 1'b1;
            st    <= ST_REL;
          end
        end
        default: begin
          buf_en_n  <= 1'b1;
          buf_dir_n <= 1'b1;
          rdy_oe    <= 1'b0;
          rd_drive  <= 1'b0;
          st        <= ST_IDLE;
        end
      endcase
    end
  end

  logic busy;
  assign busy    = (st != ST_IDLE);
  assign byte_en = busy ? lat_be : 2'b00;

  for (genvar k = 0; k < NTGT; k++) begin : g_sel
    assign tgt_sel[k] = busy && (lat_tgt == k[1:0]);
  end

  // R2: direction can only point inward while the buffers are enabled
  a_r2_dir_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_dir_n |-> !buf_en_n);
  // R7: ready is never low while its pin floats
  a_r7_rdy_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_n |-> rdy_oe);
  // R7: one edge after ready rises the buffers are closed
  a_r7_release_next: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_n) |=> (buf_en_n && !rdy_oe));
  // R6: capture pulse coincides with the falling edge of ready
  a_r6_cap_on_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cap |-> $fell(rdy_n));
  // R6: read drive only with an enabled buffer pointing outward
  a_r6_drive_dir: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive |-> (buf_dir_n && !buf_en_n));
  // R10: target select is one-hot or empty
  a_r10_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_sel));
endmodule

// File: tb/sim_hbus_handshake.sv
module sim_hbus_handshake;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_ds = 1'b0, wr_n = 1'b1, rd_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rnw = 1'b1;
  logic [1:0] tgt = 2'd0;
  logic buf_en_n, buf_dir_n, rdy_n, rdy_oe, wr_cap, rd_drive;
  logic [3:0] tgt_sel;
  logic [1:0] byte_en;

  always #10 clk = ~clk;

  hbus_handshake u0 (
    .clk(clk), .rst_n(rst_n), .mode_ds(mode_ds), .wr_n(wr_n), .rd_n(rd_n),
    .uds_n(uds_n), .lds_n(lds_n), .rnw(rnw), .tgt(tgt),
    .buf_en_n(buf_en_n), .buf_dir_n(buf_dir_n), .rdy_n(rdy_n), .rdy_oe(rdy_oe),
    .wr_cap(wr_cap), .rd_drive(rd_drive), .tgt_sel(tgt_sel), .byte_en(byte_en)
  );

  int checks = 0;
  int fails = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference: delayed strobe history and an edge age per access
  logic [3:0] hist[$];
  int  mphase = 0, age = 0, mtgt = 0, aborts = 0;
  bit  mwr = 1'b0, abort_now = 1'b0;
  bit  e_en = 1, e_dir = 1, e_rdy = 1, e_oe = 0, e_cap = 0, e_drv = 0;
  int  e_sel = -1;
  logic [1:0] e_be = 2'b00;

  function automatic int rdy_after(input bit w, input int t);
    int wt[4] = '{2, 2, 8, 5};
    int rt[4] = '{1, 4, 7, 4};
    return w ? wt[t] : rt[t];
  endfunction

  task automatic m_idle();
    e_en = 1; e_dir = 1; e_rdy = 1; e_oe = 0; e_cap = 0; e_drv = 0;
    e_sel = -1; e_be = 2'b00; mphase = 0;
  endtask

  always @(posedge clk) begin
    logic [3:0] d;
    bit dwr, drd, dsa, cur;
    int enoff, n;
    abort_now = 1'b0;
    if (!rst_n) begin
      hist.delete();
      m_idle();
    end else begin
      hist.push_back({wr_n, rd_n, uds_n, lds_n});
      if (hist.size() > 3) void'(hist.pop_front());
      d = (hist.size() == 3) ? hist[0] : 4'hF;
      dsa = !d[1] || !d[0];
      dwr = mode_ds ? (dsa && !rnw) : !d[3];
      drd = mode_ds ? (dsa && rnw)  : !d[2];
      cur = mwr ? dwr : drd;
      enoff = mwr ? 1 : 2;
      n = rdy_after(mwr, mtgt);
      case (mphase)
        0: if (dwr || drd) begin
             mwr = dwr; mtgt = int'(tgt); age = 0; mphase = 1;
             e_sel = mtgt;
             e_be = mode_ds ? {!d[1], !d[0]} : 2'b11;
           end
        1: begin
             age++;
             if (!cur) begin
               m_idle(); aborts++; abort_now = 1'b1;
             end else begin
               if (age == enoff) begin e_en = 0; e_dir = mwr ? 0 : 1; e_oe = 1; end
               if (!mwr && age == enoff + n - 1) e_drv = 1;
               if (age == enoff + n) begin e_rdy = 0; e_cap = mwr; mphase = 2; end
             end
           end
        2: begin
             e_cap = 0;
             if (!cur) begin e_rdy = 1; mphase = 3; end
           end
        default: m_idle();
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(mwr ? "R2" : "R3", "buf_en_n", buf_en_n, e_en);
      chk(mwr ? "R2" : "R3", "buf_dir_n", buf_dir_n, e_dir);
      chk(mwr ? "R4" : "R5", "rdy_n", rdy_n, e_rdy);
      chk("R7", "rdy_oe", rdy_oe, e_oe);
      chk("R6", "wr_cap", wr_cap, e_cap);
      chk("R6", "rd_drive", rd_drive, e_drv);
      chk("R10", "tgt_sel", tgt_sel, (e_sel < 0) ? 0 : (1 << e_sel));
      chk("R9", "byte_en", byte_en, e_be);
      if (abort_now) begin
        chk("R8", "abort rdy_n", rdy_n, 1);
        chk("R8", "abort buf_en_n", buf_en_n, 1);
        chk("R8", "abort rdy_oe", rdy_oe, 0);
      end
    end
  end

  task automatic access(input bit m, input bit w, input int t, input logic [1:0] be, input int hold);
    @(negedge clk);
    mode_ds = m; tgt = 2'(t); rnw = !w;
    if (!m) begin wr_n = !w; rd_n = w; end
    else begin uds_n = !be[1]; lds_n = !be[0]; end
    repeat (hold) @(negedge clk);
    wr_n = 1; rd_n = 1; uds_n = 1; lds_n = 1;
    repeat (8) @(negedge clk);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    chk("R1", "buf_en_n", buf_en_n, 1);
    chk("R1", "rdy_n", rdy_n, 1);
    chk("R1", "rdy_oe", rdy_oe, 0);
    chk("R1", "tgt_sel", tgt_sel, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "buf_dir_n after reset", buf_dir_n, 1);
    chk("R1", "wr_cap after reset", wr_cap, 0);
    // mode 0: sweep hold length so release lands before, on and after ready
    for (int w = 0; w < 2; w++)
      for (int t = 0; t < 4; t++)
        for (int h = 1; h <= 14; h++)
          access(1'b0, w[0], t, 2'b11, h);
    // mode 1: data strobes with every lane mask
    for (int w = 0; w < 2; w++)
      for (int t = 0; t < 4; t++)
        for (int b = 1; b < 4; b++)
          access(1'b1, w[0], t, 2'(b), 13);
    // R8: aborts must have been provoked by the sweep
    chk("R8", "abort count nonzero", (aborts > 0) ? 1 : 0, 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule